// File: doc/BRIEF.md
# Sparse-Map Address Decoder with Phase-Qualified Strobes

This block sits between an 8-bit processor bus with 16 address lines and the devices on one expansion board. From the address alone it raises one active-low select per memory region as soon as the address settles. This early select lets slow memories begin their access before the data phase. The shared output-enable and write-enable strobes open only during the high half of the bus clock phase (`phi2`), and only in the direction given by the read/write line.

The block also drives a data-direction request toward the processor-side bus buffers whenever a device on this board answers a read. Several boards tie this request together as a wired-OR. It is therefore modelled as a level (`dd`) plus a drive enable (`dd_oe`): the pin is driven only while the request is active and is released otherwise. The block holds no state and has no clock or reset.

Top module: `bus_strobe_decoder`

## Requirements
- R1: `sel_n` bit positions and windows (inclusive) are: bit0 main RAM 0000–0FFF, bit1 character RAM D000–D3FF, bit4 keyboard DC00–DFFF, bit5 monitor ROM E000–E3FF, bit6 spare ROM E400–E7FF, bit7 serial port FC00–FCFF, bit8 system ROM FE00–FFFF. A bit is 0 when selected.
- R2: Addresses 1000–CFFF, E800–FBFF and FD00–FDFF leave every `sel_n` bit at 1.
- R3: Graphics RAM D400–DBFF is split by address bit 10. Bit2 (bank 1) is selected when bit 10 is 1 (D400–D7FF), and bit3 (bank 2) is selected when bit 10 is 0 (D800–DBFF).
- R4: `sel_n` depends on the address only. `phi2` and `rw` never change it.
- R5: `oe_n` is 0 exactly when `phi2`=1, `rw`=1 and some region is selected.
- R6: `we_n` is 0 exactly when `phi2`=1, `rw`=0 and the selected region is writable. The writable regions are bits 0–3 and bit7.
- R7: A write to the keyboard or to any ROM region (bits 4, 5, 6, 8) leaves `we_n` at 1, even during `phi2`=1.
- R8: `dd` is 1 exactly when `rw`=1 and some region is selected, regardless of `phi2`. `dd_oe` always equals `dd`, so the pin is released when there is no request.
- R9: At most one `sel_n` bit is 0 for any address in the full 64 K space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Processor address bus |
| phi2 | input | 1 | Bus clock phase, high during data transfer |
| rw | input | 1 | 1 = read, 0 = write |
| sel_n | output | 9 | Active-low region selects (bit map in R1/R3) |
| oe_n | output | 1 | Active-low read strobe |
| we_n | output | 1 | Active-low write strobe |
| dd | output | 1 | Data-direction request level (1 = board drives a read) |
| dd_oe | output | 1 | Drive enable for the open-drain data-direction pin |

## Verification
The early address-only select and the late qualified strobe both act in the same cycle, and the data-direction request can rise alongside either of them. Every one of the 65,536 addresses is applied once with random `phi2` and `rw`. In each case the select, both strobes and the direction request are compared with values computed from the region table. Directed cases hold one address fixed while toggling `phi2` and `rw`, to show that the select does not move while the strobes and `dd` follow. Writes aimed at read-only regions are also driven to confirm that the write strobe stays closed.

// File: rtl/busmap_pkg.sv
`timescale 1ns/1ps
package busmap_pkg;
  localparam int ADDR_W      = 16;
  localparam int NUM_REGIONS = 9;

  typedef logic [ADDR_W-1:0]      addr_t;
  typedef logic [NUM_REGIONS-1:0] region_vec_t;

  // Region windows, index = select bit position
  localparam addr_t REG_LO [NUM_REGIONS] = '{
    16'h0000, 16'hD000, 16'hD400, 16'hD800, 16'hDC00,
    16'hE000, 16'hE400, 16'hFC00, 16'hFE00};
  localparam addr_t REG_HI [NUM_REGIONS] = '{
    16'h0FFF, 16'hD3FF, 16'hD7FF, 16'hDBFF, 16'hDFFF,
    16'hE3FF, 16'hE7FF, 16'hFCFF, 16'hFFFF};

  // RAM regions and the serial port accept writes
  localparam region_vec_t WRITABLE = 9'b0_1000_1111;

  function automatic logic in_window(addr_t a, addr_t lo, addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic read_phase(logic p2, logic r);
    return p2 && r;
  endfunction

  function automatic logic write_phase(logic p2, logic r);
    return p2 && !r;
  endfunction
endpackage

// File: rtl/region_match.sv
`timescale 1ns/1ps
module region_match
  import busmap_pkg::*;
#(
  parameter int N = NUM_REGIONS
) (
  input  addr_t        addr,
  output logic [N-1:0] hit
);
  for (genvar i = 0; i < N; i++) begin : g_win
    assign hit[i] = in_window(addr, REG_LO[i], REG_HI[i]);
  end
endmodule

// File: rtl/strobe_gen.sv
`timescale 1ns/1ps
module strobe_gen
  import busmap_pkg::*;
#(
  parameter int N = NUM_REGIONS
) (
  input  logic [N-1:0] hit,
  input  logic         phi2,
  input  logic         rw,
  output logic         any_hit,
  output logic         oe_n,
  output logic         we_n
);
  logic wr_ok;
  assign any_hit = |hit;
  assign wr_ok   = |(hit & WRITABLE[N-1:0]);
  assign oe_n    = !(read_phase(phi2, rw) && any_hit);
  assign we_n    = !(write_phase(phi2, rw) && wr_ok);
endmodule

// File: rtl/dd_gen.sv
`timescale 1ns/1ps
module dd_gen (
  input  logic any_hit,
  input  logic rw,
  output logic dd,
  output logic dd_oe
);
  // Wired-OR contribution: drive high only when requesting, otherwise release
  assign dd    = any_hit && rw;
  assign dd_oe = dd;
endmodule

// File: rtl/bus_strobe_decoder.sv
`timescale 1ns/1ps
module bus_strobe_decoder
  import busmap_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        phi2,
  input  logic        rw,
  output logic [8:0]  sel_n,
  output logic        oe_n,
  output logic        we_n,
  output logic        dd,
  output logic        dd_oe
);
  region_vec_t hit;
  logic        any_hit;

  region_match #(.N(NUM_REGIONS)) u_match (.addr(addr), .hit(hit));

  strobe_gen #(.N(NUM_REGIONS)) u_strobe (
    .hit(hit), .phi2(phi2), .rw(rw),
    .any_hit(any_hit), .oe_n(oe_n), .we_n(we_n));

  dd_gen u_dd (.any_hit(any_hit), .rw(rw), .dd(dd), .dd_oe(dd_oe));

  assign sel_n = ~hit;

  // Cross-module checks between the decode, strobe and direction outputs
  always_comb begin
    if (!$isunknown({addr, phi2, rw})) begin
      assert_sel_onehot_R9: assert ($onehot0(~sel_n))
        else $error("more than one select at %h", addr);
      assert_oe_qual_R5: assert (oe_n || (phi2 && rw && !(&sel_n)))
        else $error("read strobe outside a selected read phase");
      assert_we_writable_R6: assert (we_n || (phi2 && !rw &&
                                     |(~sel_n & WRITABLE)))
        else $error("write strobe without a writable target");
      assert_we_readonly_R7: assert (we_n || (sel_n[4] && sel_n[5] &&
                                     sel_n[6] && sel_n[8]))
        else $error("write strobe on a read-only region");
      assert_dd_read_R8: assert (dd == (rw && !(&sel_n)) && dd_oe == dd)
        else $error("direction request mismatch");
    end
  end
endmodule

// File: tb/test_bus_strobe_decoder.sv
`timescale 1ns/1ps
module test_bus_strobe_decoder;
  logic        clk = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        phi2 = 1'b0;
  logic        rw   = 1'b1;
  logic [8:0]  sel_n;
  logic        oe_n, we_n, dd, dd_oe;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_strobe_decoder i_bus_strobe_decoder (
    .addr(addr), .phi2(phi2), .rw(rw), .sel_n(sel_n),
    .oe_n(oe_n), .we_n(we_n), .dd(dd), .dd_oe(dd_oe));

  // Active-high expected select vector, written from the range list
  function automatic logic [8:0] exp_sel(input logic [15:0] a);
    logic [8:0] s = '0;
    if (a < 16'h1000)                       s[0] = 1'b1;
    else if (a >= 16'hD000 && a < 16'hD400) s[1] = 1'b1;
    else if (a >= 16'hD400 && a < 16'hDC00) begin
      if (a[10]) s[2] = 1'b1; else s[3] = 1'b1;
    end
    else if (a >= 16'hDC00 && a < 16'hE000) s[4] = 1'b1;
    else if (a >= 16'hE000 && a < 16'hE400) s[5] = 1'b1;
    else if (a >= 16'hE400 && a < 16'hE800) s[6] = 1'b1;
    else if (a[15:8] == 8'hFC)              s[7] = 1'b1;
    else if (a[15:9] == 7'h7F)              s[8] = 1'b1;
    return s;
  endfunction

  function automatic logic exp_writable(input logic [8:0] s);
    return s[0] || s[1] || s[2] || s[3] || s[7];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%h phi2=%b rw=%b actual=%h expected=%h",
               tag, addr, phi2, rw, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic p, input logic r);
    @(posedge clk);
    addr <= a; phi2 <= p; rw <= r;
    @(negedge clk);
  endtask

  task automatic check_all();
    logic [8:0] s = exp_sel(addr);
    string tag;
    if (s == '0) tag = "R2";
    else if (s[2] || s[3]) tag = "R3";
    else tag = "R1";
    chk(tag, {7'd0, sel_n}, {7'd0, ~s});
    chk("R9", 16'($countones(~sel_n) <= 1), 16'd1);
    chk("R5", {15'd0, oe_n}, {15'd0, !(phi2 && rw && s != '0)});
    chk("R6", {15'd0, we_n}, {15'd0, !(phi2 && !rw && exp_writable(s))});
    chk("R8", {14'd0, dd, dd_oe}, {14'd0, {2{rw && s != '0}}});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [8:0] ref_sel;
    void'($urandom(32'h1D2C_0A55));
    // Idle state at start: no phase, read direction, address 0
    @(negedge clk);
    chk("R5 idle", {15'd0, oe_n}, 16'd1);
    chk("R6 idle", {15'd0, we_n}, 16'd1);

    // R4: select does not move when phi2/rw change at fixed addresses
    foreach (ref_sel[k]) begin end
    for (int t = 0; t < 6; t++) begin
      logic [15:0] a;
      case (t)
        0: a = 16'h0FFF; 1: a = 16'hD7FF; 2: a = 16'hD800;
        3: a = 16'hFCFF; 4: a = 16'hFE00; default: a = 16'h8000;
      endcase
      for (int m = 0; m < 4; m++) begin
        apply(a, m[1], m[0]);
        chk("R4", {7'd0, sel_n}, {7'd0, ~exp_sel(a)});
        check_all();
      end
    end

    // R7: writes to read-only regions never strobe
    for (int t = 0; t < 8; t++) begin
      logic [15:0] a;
      case (t)
        0: a = 16'hDC00; 1: a = 16'hDFFF; 2: a = 16'hE000; 3: a = 16'hE3FF;
        4: a = 16'hE400; 5: a = 16'hE7FF; 6: a = 16'hFE00; default: a = 16'hFFFF;
      endcase
      apply(a, 1'b1, 1'b0);
      chk("R7", {15'd0, we_n}, 16'd1);
      check_all();
    end

    // Window edges just outside each region (R2)
    for (int t = 0; t < 6; t++) begin
      logic [15:0] a;
      case (t)
        0: a = 16'h1000; 1: a = 16'hCFFF; 2: a = 16'hE800;
        3: a = 16'hFBFF; 4: a = 16'hFD00; default: a = 16'hFDFF;
      endcase
      apply(a, 1'b1, 1'b1);
      chk("R2", {7'd0, sel_n}, 16'h01FF);
      check_all();
    end

    // Full sweep with random phase and direction (R1, R3, R9 and strobes)
    for (int i = 0; i < 65536; i++) begin
      apply(16'(i), 1'($urandom), 1'($urandom));
      check_all();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule